// File: doc/BRIEF.md
# Serial Wiper Register Slave

This block is a two-wire serial bus slave that owns an 8-bit wiper code and a shutdown flag for an external resistor network. The bus clock and data lines are oversampled in the system clock domain. The block detects bus frames, matches its own 7-bit address, and pulls the data line low through an open-drain enable to acknowledge bytes and to send read data.

In a write frame, the master sends the address byte, then an instruction byte, then one or more data bytes. The instruction byte can force the wiper code to midscale, and it can set or clear shutdown without changing the stored code. Every data byte in the frame updates the wiper and uses the instruction that was sent last. In a read frame, the stored wiper code follows the address acknowledge at once, with no instruction byte. The master may read it again as often as it acknowledges.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset the wiper code is 0x80, shutdown is 0 and the slave does not pull the data line.
- R2: The slave acknowledges an address byte whose upper six bits are 010110 and whose seventh bit equals addr_sel_i, with bit 0 as the direction (0 write, 1 read). It acknowledges by pulling the data line low during the ninth clock.
- R3: After an address byte that does not match, the slave gives no acknowledge and ignores every following byte until the next START or STOP, so the wiper code and the shutdown flag do not change.
- R4: In a write frame, the slave acknowledges the instruction byte and each data byte, and it loads each data byte into the wiper code.
- R5: Several data bytes in one write frame each update the wiper code in turn, and the last one stays.
- R6: Instruction bit 6 set to 1 loads 0x80 into the wiper code. Every data byte that follows in the same frame also leaves the code at 0x80.
- R7: Instruction bit 5 sets shutdown_o to the bit's value and leaves the wiper code unchanged. Data written during shutdown is stored, and that code is still present after shutdown is cleared.
- R8: Instruction bits 7 and 4 to 0 have no effect.
- R9: In a read frame, the wiper code is sent MSB first right after the address acknowledge. A master acknowledge makes the slave send the code again. A master NACK makes the slave release the data line until the next START or STOP.
- R10: A repeated START at any point, including the middle of a byte, returns the slave to address reception.
- R11: The slave changes its pull-down only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wired-AND) |
| addr_sel_i | input | 1 | Level that sets the lowest address bit |
| sda_pull_o | output | 1 | 1 drives the data line low (open-drain enable) |
| wiper_o | output | 8 | Stored wiper code |
| shutdown_o | output | 1 | Shutdown request for the analog switches |

## Verification
A bus line change reaches the protocol engine through two synchronizer flops and one edge-detect register. So the acknowledge pull, the next read bit and every wiper or shutdown update appear three system clocks after the bus clock falling edge that ends the relevant bit. The bench holds each bus clock phase for ten system clocks. It samples acknowledges and read bits in the middle of the bus clock high phase. It checks wiper_o and shutdown_o only after a whole byte or frame has completed, well past that three-cycle latency. Read bits are also sampled twice within each high phase, which shows that the pull-down does not move there.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_INSTR, ST_IACK,
    ST_DATA, ST_DACK, ST_READ, ST_RACK, ST_IGNORE
  } fsm_state_e;

  // instruction byte field positions
  localparam int unsigned RS_BIT = 6;
  localparam int unsigned SD_BIT = 5;
endpackage

// File: rtl/i2cw_bus_sync.sv
module i2cw_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe[0] <= 1'b1;
      sda_pipe[0] <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else begin
        scl_pipe[g] <= scl_pipe[g-1];
        sda_pipe[g] <= sda_pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2cw_frame_fsm.sv
module i2cw_frame_fsm
  import i2cw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-2:0] BASE_ADDR = 6'b010110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_sel_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              instr_en_o,
  output logic              instr_rs_o,
  output logic              instr_sd_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  fsm_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_done;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic              pull_q, rd_mode, rs_hold, ack_ok;
  logic              rx_state;

  assign rx_state   = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_DATA);
  assign sda_pull_o = pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      byte_done  <= 1'b0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      pull_q     <= 1'b0;
      rd_mode    <= 1'b0;
      rs_hold    <= 1'b0;
      ack_ok     <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_data_o  <= '0;
      instr_en_o <= 1'b0;
      instr_rs_o <= 1'b0;
      instr_sd_o <= 1'b0;
    end else begin
      wr_en_o    <= 1'b0;
      instr_en_o <= 1'b0;
      if (start_i) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        byte_done <= 1'b0;
        pull_q    <= 1'b0;
      end else if (stop_i) begin
        state     <= ST_IDLE;
        bit_cnt   <= '0;
        byte_done <= 1'b0;
        pull_q    <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise_i) begin
          rx_sh     <= {rx_sh[DATA_W-2:0], sda_s_i};
          bit_cnt   <= bit_cnt + 1'b1;
          byte_done <= (bit_cnt == LAST_BIT);
        end else if (scl_fall_i && byte_done) begin
          byte_done <= 1'b0;
          bit_cnt   <= '0;
          unique case (state)
            ST_ADDR: begin
              if (rx_sh[DATA_W-1:1] == {BASE_ADDR, addr_sel_i}) begin
                state   <= ST_AACK;
                pull_q  <= 1'b1;
                rd_mode <= rx_sh[0];
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_INSTR: begin
              state      <= ST_IACK;
              pull_q     <= 1'b1;
              instr_en_o <= 1'b1;
              instr_rs_o <= rx_sh[RS_BIT];
              instr_sd_o <= rx_sh[SD_BIT];
              rs_hold    <= rx_sh[RS_BIT];
            end
            default: begin
              state     <= ST_DACK;
              pull_q    <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_data_o <= rs_hold ? MID : rx_sh;
            end
          endcase
        end
      end else begin
        unique case (state)
          ST_AACK: if (scl_fall_i) begin
            if (rd_mode) begin
              state   <= ST_READ;
              tx_sh   <= rd_data_i;
              pull_q  <= ~rd_data_i[DATA_W-1];
              bit_cnt <= '0;
            end else begin
              state  <= ST_INSTR;
              pull_q <= 1'b0;
            end
          end
          ST_IACK, ST_DACK: if (scl_fall_i) begin
            state  <= ST_DATA;
            pull_q <= 1'b0;
          end
          ST_READ: if (scl_fall_i) begin
            if (bit_cnt == LAST_BIT) begin
              state   <= ST_RACK;
              pull_q  <= 1'b0;
              bit_cnt <= '0;
            end else begin
              tx_sh   <= tx_sh << 1;
              pull_q  <= ~tx_sh[DATA_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise_i) ack_ok <= ~sda_s_i;
            else if (scl_fall_i) begin
              if (ack_ok) begin
                state   <= ST_READ;
                tx_sh   <= rd_data_i;
                pull_q  <= ~rd_data_i[DATA_W-1];
                bit_cnt <= '0;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r11_pull_stable_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(pull_q));

  a_r2_pull_only_when_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_q |-> (state inside {ST_AACK, ST_IACK, ST_DACK, ST_READ}));

  a_r3_ignore_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE) |-> (!pull_q && !wr_en_o && !instr_en_o));

  a_r9_read_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state inside {ST_READ, ST_RACK}) |-> (!wr_en_o && !instr_en_o));
endmodule

// File: rtl/i2cw_wiper_reg.sv
module i2cw_wiper_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              instr_en_i,
  input  logic              instr_rs_i,
  input  logic              instr_sd_i,
  output logic [DATA_W-1:0] wiper_o,
  output logic              shutdown_o
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] wiper_q;
  logic              sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_q <= MID;
      sd_q    <= 1'b0;
    end else begin
      if (instr_en_i) begin
        sd_q <= instr_sd_i;
        if (instr_rs_i) wiper_q <= MID;
      end
      if (wr_en_i) wiper_q <= wr_data_i;
    end
  end

  assign wiper_o    = wiper_q;
  assign shutdown_o = sd_q;

  a_r4_wiper_changes_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wiper_q != $past(wiper_q)) |-> $past(wr_en_i || (instr_en_i && instr_rs_i)));

  a_r7_sd_changes_on_instr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_q != $past(sd_q)) |-> $past(instr_en_i));

  a_r7_sd_keeps_wiper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_en_i && !instr_rs_i && !wr_en_i) |=> $stable(wiper_q));

  a_r6_rs_gives_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_en_i && instr_rs_i && !wr_en_i) |=> (wiper_q == MID));
endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  BASE_ADDR   = 6'b010110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] wiper_o,
  output logic              shutdown_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en, instr_en, instr_rs, instr_sd;
  logic [DATA_W-1:0] wr_data;

  i2cw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2cw_frame_fsm #(.DATA_W(DATA_W), .ADDR_W(7), .BASE_ADDR(BASE_ADDR)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .addr_sel_i(addr_sel_i), .rd_data_i(wiper_o), .sda_pull_o(sda_pull_o),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .instr_en_o(instr_en),
    .instr_rs_o(instr_rs), .instr_sd_o(instr_sd)
  );

  i2cw_wiper_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .instr_en_i(instr_en), .instr_rs_i(instr_rs), .instr_sd_i(instr_sd),
    .wiper_o(wiper_o), .shutdown_o(shutdown_o)
  );
endmodule

// File: tb/i2c_wiper_slave_tb.sv
module i2c_wiper_slave_tb_top;
  localparam int HALF = 10;
  localparam logic [7:0] A_WR = 8'h58;
  localparam logic [7:0] A_RD = 8'h59;
  // {instr, data, expected wiper, expected shutdown}
  localparam logic [24:0] VEC_TBL [8] = '{
    {8'h00, 8'h3C, 8'h3C, 1'b0},
    {8'h9F, 8'hA5, 8'hA5, 1'b0},
    {8'h20, 8'h11, 8'h11, 1'b1},
    {8'h40, 8'hFF, 8'h80, 1'b0},
    {8'h60, 8'h00, 8'h80, 1'b1},
    {8'h1F, 8'hFF, 8'hFF, 1'b0},
    {8'h00, 8'h00, 8'h00, 1'b0},
    {8'h00, 8'h01, 8'h01, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_pull, shutdown;
  logic [7:0] wiper;
  logic sda_bus;
  int n_chk = 0, n_err = 0, mism = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_wiper_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .wiper_o(wiper), .shutdown_o(shutdown)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    wait_clk(2); sda_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(2); sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b);
    wait_clk(2); sda_m = b; wait_clk(HALF - 2);
    scl_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wait_clk(2); sda_m = 1'b1; wait_clk(HALF - 2);
    scl_m = 1'b1; wait_clk(HALF / 2);
    ack = ~sda_bus;
    wait_clk(HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack_m);
    logic s1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HALF); scl_m = 1'b1;
      wait_clk(2); s1 = sda_bus;
      wait_clk(HALF - 4); b[i] = sda_bus;
      if (s1 !== b[i]) mism++;
      wait_clk(2); scl_m = 1'b0;
    end
    wait_clk(2); sda_m = ~ack_m; wait_clk(HALF - 2);
    scl_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(2); sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    wait_clk(5);
    // R1 reset state
    check("R1 wiper", wiper, 8'h80);
    check("R1 shutdown", shutdown, 0);
    check("R1 pull", sda_pull, 0);
    rst_ni = 1'b1;
    wait_clk(5);

    // table: write frame then readback
    for (int v = 0; v < 8; v++) begin
      bus_start();
      send_byte(A_WR, ack);            check("R2 addr ack", ack, 1);
      send_byte(VEC_TBL[v][24:17], ack); check("R4 instr ack", ack, 1);
      send_byte(VEC_TBL[v][16:9], ack);  check("R4 data ack", ack, 1);
      bus_stop();
      check("R4/R6/R8 wiper", wiper, VEC_TBL[v][8:1]);
      check("R7/R8 shutdown", shutdown, VEC_TBL[v][0]);
      bus_start();
      send_byte(A_RD, ack);            check("R9 read addr ack", ack, 1);
      recv_byte(rd, 1'b0);             check("R9 read data", rd, VEC_TBL[v][8:1]);
      bus_stop();
    end

    // R3 mismatched address ignored
    bus_start();
    send_byte(8'h5A, ack);  check("R3 no addr ack", ack, 0);
    send_byte(8'h60, ack);  check("R3 no instr ack", ack, 0);
    send_byte(8'h33, ack);  check("R3 no data ack", ack, 0);
    bus_stop();
    check("R3 wiper kept", wiper, 8'h01);
    check("R3 shutdown kept", shutdown, 0);

    // R2 address select pin
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'h5A, ack);  check("R2 sel=1 ack", ack, 1);
    send_byte(8'h00, ack);
    send_byte(8'h44, ack);
    bus_stop();
    check("R2 sel=1 write", wiper, 8'h44);
    bus_start();
    send_byte(A_WR, ack);   check("R2 sel=1 rejects base", ack, 0);
    bus_stop();
    addr_sel = 1'b0;

    // R5 several data bytes
    bus_start();
    send_byte(A_WR, ack);
    send_byte(8'h00, ack);
    send_byte(8'h10, ack);
    send_byte(8'h20, ack);  check("R5 second data ack", ack, 1);
    check("R5 mid-frame wiper", wiper, 8'h20);
    send_byte(8'h30, ack);
    bus_stop();
    check("R5 last data", wiper, 8'h30);

    // R6 midscale held over data bytes
    bus_start();
    send_byte(A_WR, ack);
    send_byte(8'h40, ack);
    check("R6 mid after instr", wiper, 8'h80);
    send_byte(8'h12, ack);
    send_byte(8'h34, ack);
    bus_stop();
    check("R6 mid held", wiper, 8'h80);

    // R7 shutdown without data, then clear, code kept
    bus_start(); send_byte(A_WR, ack); send_byte(8'h00, ack); send_byte(8'h5E, ack); bus_stop();
    bus_start(); send_byte(A_WR, ack); send_byte(8'h20, ack); bus_stop();
    check("R7 sd set", shutdown, 1);
    check("R7 wiper kept in sd", wiper, 8'h5E);
    bus_start(); send_byte(A_WR, ack); send_byte(8'h00, ack); bus_stop();
    check("R7 sd cleared", shutdown, 0);
    check("R7 wiper after sd", wiper, 8'h5E);

    // R9 repeated read, NACK release
    bus_start();
    send_byte(A_RD, ack);
    recv_byte(rd, 1'b1);  check("R9 first read", rd, 8'h5E);
    recv_byte(rd, 1'b0);  check("R9 repeat read", rd, 8'h5E);
    wait_clk(HALF);
    check("R9 released after NACK", sda_bus, 1);
    bus_stop();
    check("R11 read bits stable in high phase", mism, 0);

    // R10 repeated start mid data byte
    bus_start();
    send_byte(A_WR, ack);
    send_byte(8'h00, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(A_WR, ack);  check("R10 addr after rstart", ack, 1);
    send_byte(8'h00, ack);
    send_byte(8'h77, ack);
    bus_start();
    send_byte(A_RD, ack);  check("R10 read after rstart", ack, 1);
    recv_byte(rd, 1'b0);   check("R10 read value", rd, 8'h77);
    bus_stop();
    check("R10 wiper", wiper, 8'h77);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule